// File: doc/BRIEF.md
# Register-RAM Arithmetic Datapath

This block is the 8-bit execution core of a small processor in which every programmer-visible register sits in one small RAM instead of in separate flip-flops. The RAM has a data-in port and a data-out port on separate wires. The read is combinational from the register index. The write happens at the clock edge. This arrangement works because no operation ever needs more than one register at a time. In each cycle the datapath reads one entry, sends it through one shared adder/subtractor and then through a multiplexer that performs shifts and rotates. It can write the result back into the same entry.

The same adder serves data arithmetic, increment and decrement of an index, stack-pointer adjustment, register transfers and stepping of the program counter. To step the program counter, the low byte is passed with a zero operand and a carry-in of 1. The carry that comes out is then fed in as the carry-in when the high byte is passed in the next cycle. The storage is built from 4-bit-wide RAM slices placed side by side. Instruction decode, buses and memory sit outside this block and drive its inputs.

Top module: `regram_datapath`

## Requirements
- R1: A synchronous active-low reset clears all 16 register entries to 0x00. A read of any entry after reset returns 0 with the zero flag set.
- R2: When `wr_en` is 1 at a rising clock edge, `result` is stored in the entry selected by `reg_sel`. No other entry changes.
- R3: The read is combinational from `reg_sel`. In a cycle that also writes that entry, `result` is computed from the old contents. The new value is visible from the next cycle.
- R4: Operation code 0x0 (add) gives reg + `ext_operand` + `carry_in`. `carry_out` is the carry from bit 7.
- R5: Operation code 0x1 (subtract) gives reg + ~`ext_operand` + `carry_in`, so a `carry_in` of 1 means no borrow. `carry_out` is 1 when no borrow occurs.
- R6: Operation code 0x2 (pass) gives reg + `carry_in`. With a `carry_in` of 1 this is an increment, and an entry of 0xFF gives 0x00 with `carry_out` 1. Feeding that carry into the pass of the next entry steps a 16-bit counter.
- R7: Operation code 0x3 (decrement) gives reg + 0xFF + `carry_in`. With a `carry_in` of 0 the result is reg − 1, and `carry_out` is 0 only when the entry was 0x00.
- R8: Operation code 0x4 (load) gives `ext_operand` + `carry_in`, ignoring the register contents. `carry_out` is the adder carry.
- R9: Code 0x8 shifts left and fills bit 0 with `carry_in`. Code 0x9 shifts right and fills bit 7 with `carry_in`. In both cases `carry_out` is the bit shifted out.
- R10: Code 0xA rotates left, with bit 7 going to bit 0. Code 0xB rotates right, with bit 0 going to bit 7. In both cases `carry_out` is the bit that moved across the end.
- R11: `flag_z` is 1 exactly when `result` is 0, and `flag_n` equals `result` bit 7, for every operation. `flag_v` shows signed overflow for add and subtract and is 0 for every other code.
- R12: Any operation code not listed above behaves as pass (reg + `carry_in`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the RAM write and reset act on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 4 | Index of the register entry that is read and, if enabled, written |
| alu_op | input | 4 | Operation code (see R4 to R12) |
| carry_in | input | 1 | Carry into the adder, or fill bit for shifts |
| ext_operand | input | 8 | Operand from outside the register file |
| wr_en | input | 1 | Write `result` back into the selected entry at the clock edge |
| result | output | 8 | Output of the shifter stage |
| carry_out | output | 1 | Adder carry, or the bit moved out by a shift or rotate |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 7 |
| flag_v | output | 1 | Signed overflow (add and subtract only) |

## Verification
Some properties are checked on every cycle. These are: a write leaves the written data in the addressed RAM slice on the next cycle; an increment of 0xFF wraps to zero with a carry; load shows the external operand; a left shift fills from the carry and sends out bit 7; and overflow stays low outside add and subtract. Other behaviour can only be shown by the bench's scenarios. These are: the cleared state after reset; old-value reads while the same entry is written; the carry handed from one program-counter byte to the next; entries left untouched by writes elsewhere; and the arithmetic, borrow and rotate results under directed and pseudo-random operands.

// File: rtl/regram_pkg.sv
// Shared definitions for the register-RAM datapath.
// Assumes an operation field 4 bits wide; bit 3 selects the shift group.
package regram_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_PASS = 4'h2,
        OP_DEC  = 4'h3,
        OP_LOAD = 4'h4,
        OP_SHL  = 4'h8,
        OP_SHR  = 4'h9,
        OP_ROL  = 4'hA,
        OP_ROR  = 4'hB
    } alu_op_e;
endpackage

// File: rtl/ram_slice.sv
// One narrow register-file slice: combinational read, synchronous write.
// Assumes a single shared address for read and write; reset clears contents.
module ram_slice #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] store [DEPTH];

    // Clear on reset, otherwise write the addressed entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[addr] <= din;
        end
    end

    // Read port is a plain combinational lookup of the current contents.
    assign dout = store[addr];

    // R2: written data is held in the addressed entry on the following cycle.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (store[$past(addr)] == $past(din)));
endmodule

// File: rtl/regram_file.sv
// Register file assembled from side-by-side RAM slices.
// Assumes DATA_W is a whole multiple of SLICE_W.
module regram_file #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int SLICE_W = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int NSLICE = DATA_W / SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    // One slice per SLICE_W-bit lane of the data word.
    for (genvar s = 0; s < NSLICE; s++) begin : g_lane
        ram_slice #(.DEPTH(DEPTH), .WIDTH(SLICE_W)) u_slice (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (addr),
            .we   (we),
            .din  (wdata[s*SLICE_W +: SLICE_W]),
            .dout (rdata[s*SLICE_W +: SLICE_W])
        );
    end
endmodule

// File: rtl/alu_adder.sv
// Shared adder/subtractor: picks operand B and carry from the operation,
// produces sum, carry and signed overflow. Overflow is reported for add/subtract only.
module alu_adder
    import regram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] ext,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    logic [DATA_W-1:0] opa, opb;
    logic              c0;
    logic              arith;

    // Operand steering for each operation code.
    always_comb begin
        opa   = a;
        opb   = '0;
        c0    = cin;
        arith = 1'b0;
        unique case (op)
            OP_ADD:  begin opb = ext;  arith = 1'b1; end
            OP_SUB:  begin opb = ~ext; arith = 1'b1; end
            OP_DEC:  opb = '1;
            OP_LOAD: begin opa = '0; opb = ext; end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: c0 = 1'b0;
            default: ;
        endcase
    end

    // Single carry-propagate addition.
    always_comb begin
        {cout, sum} = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, c0};
        ovf = arith & (opa[DATA_W-1] == opb[DATA_W-1]) & (sum[DATA_W-1] != opa[DATA_W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
// Shift/rotate multiplexer on the adder output; passes the adder through otherwise.
// Assumes the adder presents the unmodified register for shift codes.
module alu_shifter
    import regram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] sum,
    input  logic              add_cout,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;

    // Select shifted word and the bit moved out.
    always_comb begin
        unique case (op)
            OP_SHL:  begin res = {sum[MSB-1:0], cin};     cout = sum[MSB]; end
            OP_SHR:  begin res = {cin, sum[MSB:1]};       cout = sum[0];   end
            OP_ROL:  begin res = {sum[MSB-1:0], sum[MSB]}; cout = sum[MSB]; end
            OP_ROR:  begin res = {sum[0], sum[MSB:1]};    cout = sum[0];   end
            default: begin res = sum;                     cout = add_cout; end
        endcase
    end
endmodule

// File: rtl/regram_datapath.sv
// Top of the register-RAM datapath: one RAM read, one adder pass, one shift
// stage and optional write-back per cycle. Assumes decode drives all inputs.
module regram_datapath
    import regram_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int SLICE_W = 4,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_sel,
    input  logic [3:0]        alu_op,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] ext_operand,
    input  logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v
);
    alu_op_e           op;
    logic [DATA_W-1:0] rd_data, sum;
    logic              add_c;

    // Operation code as the shared enum.
    assign op = alu_op_e'(alu_op);

    regram_file #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLICE_W(SLICE_W)) u_file (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (reg_sel),
        .we   (wr_en),
        .wdata(result),
        .rdata(rd_data)
    );

    alu_adder #(.DATA_W(DATA_W)) u_add (
        .op  (op),
        .a   (rd_data),
        .ext (ext_operand),
        .cin (carry_in),
        .sum (sum),
        .cout(add_c),
        .ovf (flag_v)
    );

    alu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op      (op),
        .sum     (sum),
        .add_cout(add_c),
        .cin     (carry_in),
        .res     (result),
        .cout    (carry_out)
    );

    // Zero and sign flags from the final result.
    always_comb begin
        flag_z = (result == '0);
        flag_n = result[DATA_W-1];
    end

    // R6: increment of an all-ones entry wraps to zero and raises the carry.
    a_r6_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PASS && carry_in && rd_data == '1) |-> (carry_out && result == '0));

    // R8: load presents the external operand when no carry is added.
    a_r8_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD && !carry_in) |-> (result == ext_operand && !carry_out));

    // R9: left shift fills from the carry and emits the old top bit.
    a_r9_shl_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHL) |-> (result == {rd_data[DATA_W-2:0], carry_in} && carry_out == rd_data[DATA_W-1]));

    // R11: overflow stays low outside add and subtract.
    a_r11_v_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_ADD && op != OP_SUB) |-> !flag_v);
endmodule

// File: tb/regram_datapath_test.sv
module regram_datapath_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [3:0] alu_op = 4'h2;
    logic       carry_in = 1'b0;
    logic [7:0] ext_operand = '0;
    logic       wr_en = 1'b0;
    logic [7:0] result;
    logic       carry_out, flag_z, flag_n, flag_v;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0]  model [16];
    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    regram_datapath uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .alu_op(alu_op),
        .carry_in(carry_in), .ext_operand(ext_operand), .wr_en(wr_en),
        .result(result), .carry_out(carry_out), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    // Expected {result, c, z, n, v} from the requirement text.
    function automatic logic [11:0] predict(logic [3:0] op, logic [7:0] a, logic [7:0] e, logic c);
        logic [8:0] s;
        logic [7:0] r;
        logic co, v;
        v = 1'b0;
        case (op)
            4'h0: begin s = a + e + c; v = (a[7] == e[7]) && (s[7] != a[7]); end
            4'h1: begin s = a + {1'b0, ~e} + c; v = (a[7] != e[7]) && (s[7] != a[7]); end
            4'h3: s = a + 9'h0FF + c;
            4'h4: s = e + c;
            default: s = a + c;
        endcase
        r = s[7:0]; co = s[8];
        case (op)
            4'h8: begin r = {a[6:0], c};    co = a[7]; end
            4'h9: begin r = {c, a[7:1]};    co = a[0]; end
            4'hA: begin r = {a[6:0], a[7]}; co = a[7]; end
            4'hB: begin r = {a[0], a[7:1]}; co = a[0]; end
            default: ;
        endcase
        return {r, co, (r == 8'h00), r[7], v};
    endfunction

    // Driver: apply one operation for one cycle and queue its expected outputs.
    task automatic drive(input logic [3:0] sel, input logic [3:0] op, input logic c,
                         input logic [7:0] e, input logic we, input string tag);
        logic [11:0] x;
        @(posedge clk);
        #1;
        reg_sel = sel; alu_op = op; carry_in = c; ext_operand = e; wr_en = we;
        x = predict(op, model[sel], e, c);
        exp_q.push_back(x);
        tag_q.push_back(tag);
        if (we) model[sel] = x[11:4];
    endtask

    // Monitor: compare outputs mid-cycle against the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [11:0] x;
            logic [11:0] got;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {result, carry_out, flag_z, flag_n, flag_v};
            checks++;
            if (got !== x) begin
                fails++;
                $display("FAIL %s: got r=%h c=%b z=%b n=%b v=%b expected r=%h c=%b z=%b n=%b v=%b",
                         t, got[11:4], got[3], got[2], got[1], got[0],
                         x[11:4], x[3], x[2], x[1], x[0]);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every entry reads zero after reset.
        for (int i = 0; i < 16; i++) drive(4'(i), 4'h2, 1'b0, 8'h00, 1'b0, "R1");

        // R8: loads through the load code.
        drive(4'd0, 4'h4, 1'b0, 8'h50, 1'b1, "R8");
        drive(4'd1, 4'h4, 1'b0, 8'h30, 1'b1, "R8");
        drive(4'd2, 4'h4, 1'b0, 8'h80, 1'b1, "R8");
        drive(4'd3, 4'h4, 1'b1, 8'h00, 1'b1, "R8");
        drive(4'd4, 4'h4, 1'b0, 8'hFF, 1'b1, "R8");
        drive(4'd5, 4'h4, 1'b0, 8'h12, 1'b1, "R8");

        // R2: untouched entry still zero, written entry holds its value.
        drive(4'd6, 4'h2, 1'b0, 8'hAA, 1'b0, "R2");
        drive(4'd0, 4'h2, 1'b0, 8'hAA, 1'b0, "R2");

        // R4 / R11: signed overflow and carry-out.
        drive(4'd0, 4'h0, 1'b0, 8'h30, 1'b0, "R4");
        drive(4'd4, 4'h0, 1'b0, 8'h01, 1'b0, "R4");
        drive(4'd1, 4'h0, 1'b1, 8'h0F, 1'b0, "R4");

        // R5: borrow and overflow on subtract.
        drive(4'd0, 4'h1, 1'b1, 8'h60, 1'b0, "R5");
        drive(4'd2, 4'h1, 1'b1, 8'h01, 1'b0, "R5");
        drive(4'd0, 4'h1, 1'b0, 8'h50, 1'b0, "R5");

        // R6: two-byte counter step, low byte wraps and carries into high.
        drive(4'd4, 4'h2, 1'b1, 8'h00, 1'b1, "R6");
        drive(4'd5, 4'h2, 1'b1, 8'h00, 1'b1, "R6");
        drive(4'd4, 4'h2, 1'b0, 8'h00, 1'b0, "R6");
        drive(4'd5, 4'h2, 1'b0, 8'h00, 1'b0, "R6");

        // R3: back-to-back increments of the same entry see the old value.
        drive(4'd1, 4'h2, 1'b1, 8'h00, 1'b1, "R3");
        drive(4'd1, 4'h2, 1'b1, 8'h00, 1'b1, "R3");
        drive(4'd1, 4'h2, 1'b0, 8'h00, 1'b0, "R3");

        // R7: decrement to zero, then through zero.
        drive(4'd3, 4'h3, 1'b0, 8'h00, 1'b1, "R7");
        drive(4'd3, 4'h3, 1'b0, 8'h00, 1'b1, "R7");

        // R9 / R10: shifts and rotates.
        drive(4'd2, 4'h8, 1'b1, 8'h00, 1'b0, "R9");
        drive(4'd0, 4'h9, 1'b1, 8'h00, 1'b0, "R9");
        drive(4'd2, 4'hA, 1'b0, 8'h00, 1'b0, "R10");
        drive(4'd0, 4'hB, 1'b1, 8'h00, 1'b0, "R10");
        drive(4'd2, 4'hB, 1'b1, 8'h00, 1'b1, "R10");

        // R12: unlisted codes act as pass.
        drive(4'd0, 4'h7, 1'b0, 8'hEE, 1'b0, "R12");
        drive(4'd1, 4'hF, 1'b1, 8'hEE, 1'b0, "R12");

        // R11: pseudo-random mix over all codes and entries.
        lcg = 32'h1234_5678;
        for (int k = 0; k < 300; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            drive(lcg[3:0], lcg[11:8], lcg[12], lcg[23:16], lcg[13], "R11");
        end

        @(posedge clk);
        #1 wr_en = 1'b0;
        @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule